// File: doc/BRIEF.md
# Power and Sleep Controller

This block holds the clock and reset state of a set of peripheral modules that are grouped into power domains. Software uses a small register file to write a requested state for each module and a next power state for each domain. It then starts a transition for one or more domains by writing a command word. The controller moves every module of that domain to its requested state. While it does so, a per-domain busy bit reads high.

A domain whose status shows it as off does not power up on its own. Software sets the domain's next-state bit and issues the command. The controller then raises a pending flag toward the external power-switch logic and stalls. The transition continues only after software writes the power-good bit in the domain control register.

Each module drives a clock-enable output and an active-low reset output that follow its state. Before a module leaves a clocked state, it must report idle, unless its force bit is set. The module-to-domain mapping is fixed by a parameter, 4 bits per module. Each module state change takes a fixed number of cycles, so software can see the busy bit.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset every module is in state 0 (software-reset-disable), so its clock enable is 0 and its reset is asserted. The transition status at 0x004 and the pending register at 0x008 read 0. A domain's status (0x200 + 4*d, bit 0) reads 1 for the domains set in DOM_ON_RST (default: domain 0 only) and 0 for the rest.
- R2: A write to the module control register (0x400 + 4*m) stores the requested state in bits [1:0] and the force flag in bit 8, and both read back. The write leaves the module's current state unchanged until its domain runs a transition.
- R3: Writing 1 to bit d of the command register 0x000 starts a transition for domain d, and bit d of 0x004 reads 1 until it ends. A command write with bit d at 0 does not start domain d.
- R4: At the end of a transition, bits [1:0] of each module status register (0x500 + 4*m) equal the requested state, using the encoding 0 = software-reset-disable, 1 = synchronous reset, 2 = disable, 3 = enable. Bit 12 of the same register is 1 exactly when the state is 1 or 3.
- R5: The mod_clk_en output for a module is 1 only when the module's state bit 0 is 1 and its domain is on. The mod_rst_n output equals state bit 1.
- R6: If a domain is off and bit 0 (next) of its control register (0x100 + 4*d) is 1, a command for that domain sets bit d of 0x008 and of dom_pwr_pend. The domain then stays off and its modules keep their states until software writes 1 to control bit 1 (power-good).
- R7: Once power-good is seen, pending clears on the next edge, the domain status and dom_pwr_on read 1, power-good clears itself, and the domain's modules move to their requested states.
- R8: A command for a domain that is on, with next = 0, applies the module requests without raising pending. It then turns the domain off, so status bit 0 and dom_pwr_on read 0.
- R9: A module in state 1 or 3 that is asked for state 0 or 2 waits, keeping its domain busy, until its mod_idle input is 1. If its force bit is set, it moves without waiting.
- R10: A transition changes only modules mapped to the commanded domain. Modules of other domains keep their state even if they have pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, same cycle |
| mod_idle | input | N_MOD | Per-module idle report used before clock stop |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module active-low reset |
| dom_pwr_on | output | N_DOM | Per-domain power-on state |
| dom_pwr_pend | output | N_DOM | Per-domain request waiting for power-good |

## Verification
Suppose a domain sequencer is stuck or skips a phase. The busy bit in 0x004 then either never clears or never rises. If it skips the power-good wait, the pending flag or dom_pwr_on changes one edge too early. All of this shows within a few cycles of the command write. A wrong module state or step count shows in the module status register and on mod_clk_en and mod_rst_n once the transition is polled to completion. A module moved in the wrong domain stays visible afterwards in the status of its neighbours. A missing idle or force check shows as a clock enable that drops while the bench is still holding mod_idle low.

// File: rtl/pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl #(
  parameter int N_DOM = 4,
  parameter int N_MOD = 16,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int STEP_DLY = 3,
  parameter logic [4*N_MOD-1:0] MOD_DOM_MAP = 64'h3333_2222_1111_0000,
  parameter logic [N_DOM-1:0] DOM_ON_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wen,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_MOD-1:0] mod_idle,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst_n,
  output logic [N_DOM-1:0] dom_pwr_on,
  output logic [N_DOM-1:0] dom_pwr_pend
);
  localparam int CW = $clog2(STEP_DLY + 1);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_PWAIT = 2'd1, PH_MODS = 2'd2;
  localparam logic [3:0] RG_GLB = 4'h0, RG_DCTL = 4'h1, RG_DSTAT = 4'h2,
                         RG_MCTL = 4'h4, RG_MSTAT = 4'h5;

  logic [1:0]       m_req [N_MOD];
  logic [1:0]       m_st  [N_MOD];
  logic [CW-1:0]    m_cnt [N_MOD];
  logic [N_MOD-1:0] m_force, m_busy, m_go, m_inmods, m_domon;

  logic [1:0]       d_ph [N_DOM];
  logic [N_DOM-1:0] d_next, d_pgood, d_on, d_left, d_busy;

  wire [3:0] region = reg_addr[11:8];
  wire [5:0] idx    = reg_addr[7:2];
  wire       cmd_wr = reg_wen && region == RG_GLB && idx == 6'd0;

  genvar gm, gd;
  generate
    for (gm = 0; gm < N_MOD; gm++) begin : g_mod
      localparam int DM = int'(MOD_DOM_MAP[4*gm +: 4]);
      assign m_inmods[gm] = d_ph[DM] == PH_MODS;
      assign m_domon[gm]  = d_on[DM];
      assign m_busy[gm]   = m_inmods[gm] && (m_st[gm] != m_req[gm]);
      assign m_go[gm]     = m_busy[gm] &&
                            !(m_st[gm][0] && !m_req[gm][0] && !mod_idle[gm] && !m_force[gm]);
      assign mod_clk_en[gm] = m_st[gm][0] & m_domon[gm];
      assign mod_rst_n[gm]  = m_st[gm][1];

      assert_state_moves_in_transition_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_st[gm]) |-> $past(d_ph[DM] == PH_MODS));
      assert_clock_stop_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_st[gm][0]) |-> $past(mod_idle[gm] || m_force[gm]));
    end

    for (gd = 0; gd < N_DOM; gd++) begin : g_dom
      assign d_busy[gd]       = d_ph[gd] != PH_IDLE;
      assign dom_pwr_pend[gd] = d_ph[gd] == PH_PWAIT;
      assign dom_pwr_on[gd]   = d_on[gd];

      assert_pending_only_while_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dom_pwr_pend[gd] |-> !dom_pwr_on[gd]);
      assert_power_up_after_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_pwr_on[gd]) |-> $past(dom_pwr_pend[gd]));
      assert_busy_starts_on_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_busy[gd]) |-> $past(cmd_wr && reg_wdata[gd]));
    end
  endgenerate

  always_comb begin
    d_left = '0;
    for (int d = 0; d < N_DOM; d++)
      for (int m = 0; m < N_MOD; m++)
        if (MOD_DOM_MAP[4*m +: 4] == 4'(d) && m_busy[m]) d_left[d] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MOD; m++) begin
        m_req[m] <= 2'd0;
        m_st[m]  <= 2'd0;
        m_cnt[m] <= '0;
      end
      m_force <= '0;
    end else begin
      for (int m = 0; m < N_MOD; m++) begin
        if (reg_wen && region == RG_MCTL && idx == 6'(m)) begin
          m_req[m]   <= reg_wdata[1:0];
          m_force[m] <= reg_wdata[8];
        end
        if (!m_go[m]) m_cnt[m] <= '0;
        else if (m_cnt[m] == CW'(STEP_DLY - 1)) begin
          m_st[m]  <= m_req[m];
          m_cnt[m] <= '0;
        end else m_cnt[m] <= m_cnt[m] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < N_DOM; d++) d_ph[d] <= PH_IDLE;
      d_next  <= DOM_ON_RST;
      d_on    <= DOM_ON_RST;
      d_pgood <= '0;
    end else begin
      for (int d = 0; d < N_DOM; d++) begin
        case (d_ph[d])
          PH_IDLE:
            if (cmd_wr && reg_wdata[d]) begin
              d_pgood[d] <= 1'b0;
              d_ph[d]    <= (!d_on[d] && d_next[d]) ? PH_PWAIT : PH_MODS;
            end
          PH_PWAIT:
            if (d_pgood[d]) begin
              d_pgood[d] <= 1'b0;
              d_on[d]    <= 1'b1;
              d_ph[d]    <= PH_MODS;
            end
          PH_MODS:
            if (!d_left[d]) begin
              d_on[d] <= d_next[d];
              d_ph[d] <= PH_IDLE;
            end
          default: d_ph[d] <= PH_IDLE;
        endcase
        if (reg_wen && region == RG_DCTL && idx == 6'(d)) begin
          d_next[d] <= reg_wdata[0];
          if (reg_wdata[1]) d_pgood[d] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (region)
      RG_GLB:
        if (idx == 6'd1) reg_rdata[N_DOM-1:0] = d_busy;
        else if (idx == 6'd2) reg_rdata[N_DOM-1:0] = dom_pwr_pend;
      RG_DCTL:
        for (int d = 0; d < N_DOM; d++)
          if (idx == 6'(d)) begin
            reg_rdata[0] = d_next[d];
            reg_rdata[1] = d_pgood[d];
          end
      RG_DSTAT:
        for (int d = 0; d < N_DOM; d++)
          if (idx == 6'(d)) reg_rdata[0] = d_on[d];
      RG_MCTL:
        for (int m = 0; m < N_MOD; m++)
          if (idx == 6'(m)) begin
            reg_rdata[1:0] = m_req[m];
            reg_rdata[8]   = m_force[m];
          end
      RG_MSTAT:
        for (int m = 0; m < N_MOD; m++)
          if (idx == 6'(m)) begin
            reg_rdata[1:0] = m_st[m];
            reg_rdata[12]  = m_st[m][0];
          end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb;
  logic        clk = 0, rst_n = 0, reg_wen = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] mod_idle = '0, mod_clk_en, mod_rst_n;
  logic [3:0]  dom_pwr_on, dom_pwr_pend;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  pwr_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_idle(mod_idle),
    .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n),
    .dom_pwr_on(dom_pwr_on), .dom_pwr_pend(dom_pwr_pend));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input int d, input string tag);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(12'h004, v);
      if (!v[d]) return;
    end
    chk({tag, " transition finishes"}, 32'd1, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h500, v); chk("R1 module 0 state", v, 32'h0);
    chk("R1 clock enables", {16'h0, mod_clk_en}, 32'h0);
    chk("R1 resets asserted", {16'h0, mod_rst_n}, 32'h0);
    rd(12'h200, v); chk("R1 domain 0 on", v, 32'h1);
    rd(12'h204, v); chk("R1 domain 1 off", v, 32'h0);
    rd(12'h004, v); chk("R1 transition status", v, 32'h0);
    rd(12'h008, v); chk("R1 pending", v, 32'h0);
  endtask

  task automatic t_enable_dom0();
    logic [31:0] v;
    wr(12'h400, 32'h3);
    wr(12'h404, 32'h101);
    wr(12'h420, 32'h3);
    rd(12'h404, v); chk("R2 control readback", v, 32'h101);
    rd(12'h500, v); chk("R2 state unchanged before command", v, 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h004, v); chk("R3 zero command starts nothing", v, 32'h0);
    wr(12'h000, 32'h1);
    rd(12'h004, v); chk("R3 busy after command", v, 32'h1);
    wait_idle(0, "R3");
    rd(12'h500, v); chk("R4 module 0 enabled", v, 32'h1003);
    rd(12'h504, v); chk("R4 module 1 sync reset", v, 32'h1001);
    chk("R5 module 0 clk/rst", {30'h0, mod_clk_en[0], mod_rst_n[0]}, 32'h3);
    chk("R5 module 1 clk/rst", {30'h0, mod_clk_en[1], mod_rst_n[1]}, 32'h2);
    rd(12'h520, v); chk("R10 other domain module held", v, 32'h0);
    wr(12'h404, 32'h1);
  endtask

  task automatic t_power_on_dom1();
    logic [31:0] v;
    wr(12'h410, 32'h3);
    wr(12'h104, 32'h1);
    wr(12'h000, 32'h2);
    repeat (10) @(negedge clk);
    rd(12'h008, v); chk("R6 pending bit", v, 32'h2);
    chk("R6 pending output", {28'h0, dom_pwr_pend}, 32'h2);
    rd(12'h204, v); chk("R6 domain still off", v, 32'h0);
    rd(12'h510, v); chk("R6 module held", v, 32'h0);
    rd(12'h004, v); chk("R6 busy while waiting", v, 32'h2);
    wr(12'h104, 32'h3);
    rd(12'h008, v); chk("R7 pending cleared", v, 32'h0);
    rd(12'h204, v); chk("R7 domain on", v, 32'h1);
    rd(12'h104, v); chk("R7 power-good self clears", v, 32'h1);
    wait_idle(1, "R7");
    rd(12'h510, v); chk("R7 module enabled", v, 32'h1003);
    chk("R7 clock on", {31'h0, mod_clk_en[4]}, 32'h1);
    rd(12'h520, v); chk("R10 domain 2 module held", v, 32'h0);
  endtask

  task automatic t_idle_gate();
    logic [31:0] v;
    wr(12'h400, 32'h2);
    wr(12'h000, 32'h1);
    repeat (20) @(negedge clk);
    rd(12'h004, v); chk("R9 busy while not idle", v, 32'h1);
    rd(12'h500, v); chk("R9 state held", v, 32'h1003);
    mod_idle[0] = 1;
    wait_idle(0, "R9");
    rd(12'h500, v); chk("R9 disabled after idle", v, 32'h2);
    chk("R5 disabled clk/rst", {30'h0, mod_clk_en[0], mod_rst_n[0]}, 32'h1);
    wr(12'h404, 32'h100);
    wr(12'h000, 32'h1);
    wait_idle(0, "R9");
    rd(12'h504, v); chk("R9 force bypasses idle", v, 32'h0);
  endtask

  task automatic t_power_off_dom1();
    logic [31:0] v;
    mod_idle[4] = 1;
    wr(12'h410, 32'h2);
    wr(12'h104, 32'h0);
    wr(12'h000, 32'h2);
    rd(12'h008, v); chk("R8 no pending on power-off", v, 32'h0);
    wait_idle(1, "R8");
    rd(12'h204, v); chk("R8 domain off", v, 32'h0);
    chk("R8 power output", {28'h0, dom_pwr_on}, 32'h1);
    rd(12'h510, v); chk("R8 module disabled", v, 32'h2);
    chk("R5 clock off", {31'h0, mod_clk_en[4]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable_dom0();
    t_power_on_dom1();
    t_idle_gate();
    t_power_off_dom1();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule